// File: doc/BRIEF.md
# Sixteen-Bit Immediate Execute Unit

This unit computes the result of the register-immediate operations that carry a 16-bit literal. Given an operation code, the literal and the current contents of the destination register, it produces the new 64-bit register value. The result appears one clock after the request.

It supports five operations:

- loading the literal with zero fill above it;
- loading the literal with one fill above it;
- adding the sign-extended literal to the register;
- shifting the register left by sixteen and placing the literal in the vacated low bits;
- reading the literal as an IEEE binary16 number and widening it exactly to binary64.

The widening path lets common floating-point constants such as 1.0, 0.5 or 1.5 be encoded in a 16-bit field. Register-file access and instruction decode belong to the surrounding pipeline.

The three unused operation codes are reported through an illegal-operation flag. In that case the result is forced to zero. A parameter can remove the floating-point path. That code then joins the illegal ones.

Top module: `imm16_exec`

## Requirements
- R1: Operation code 0 (zero-fill load) returns the literal in bits 15:0 with bits 63:16 cleared.
- R2: Operation code 1 (one-fill load) returns the literal in bits 15:0 with bits 63:16 all set.
- R3: Operation code 2 (add) returns the register value plus the sign-extended literal, wrapping modulo 2^64.
- R4: Operation code 3 (shift-insert) returns (register << 16) with the literal in bits 15:0.
- R5: Operation code 4 (half load) converts normal binary16 values exactly: the sign is bit 63, the exponent is rebiased from 15 to 1023 into bits 62:52, and the 10 mantissa bits land in bits 51:42. For example, 0x3C00 gives 0x3FF0000000000000 and 0xB800 gives 0xBFE0000000000000.
- R6: Binary16 subnormals (exponent field 0, mantissa nonzero) are normalised exactly. For example, 0x0001 gives 2^-24 = 0x3E70000000000000.
- R7: Signed zeros keep their sign, and infinities map to infinities. A NaN maps to exponent 0x7FF with bit 51 set and the low nine mantissa bits copied into bits 50:42.
- R8: Operation codes 5, 6 and 7 raise the illegal flag with a result of zero. Legal codes leave the flag low.
- R9: A request accepted with the valid input on a rising edge appears on the outputs after that edge, with the valid output high for exactly that cycle.
- R10: While the valid input is low, the valid output is low on the following cycle and the result and flag hold their last values.
- R11: During reset, the valid output, the result and the illegal flag are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe |
| req_op | input | 3 | Operation code (0 to 7) |
| req_imm | input | 16 | Immediate literal |
| req_reg | input | 64 | Current destination register value |
| rsp_valid | output | 1 | Result strobe, one cycle after the request |
| rsp_data | output | 64 | Computed register value |
| rsp_illegal | output | 1 | Unused operation code seen |

## Verification
The assertions assume that `req_op`, `req_imm` and `req_reg` are stable and known whenever `req_valid` is high at a rising edge. They relate each response only to the inputs sampled at that edge. The stimulus always changes inputs on the falling edge, so each sampled request is fully settled. Constrained random requests spread the operation codes over all eight values, including the illegal ones. Every one of the 65536 binary16 encodings is driven through the half-load path, which covers subnormal, infinite and NaN inputs.

// File: rtl/imm16_pkg.sv
package imm16_pkg;
   typedef enum logic [2:0] {
      OP_LDZ  = 3'd0,
      OP_LDO  = 3'd1,
      OP_ADD  = 3'd2,
      OP_SHI  = 3'd3,
      OP_HALF = 3'd4
   } imm_op_e;
endpackage

// File: rtl/imm16_intops.sv
module imm16_intops #(
   parameter int XLEN  = 64,
   parameter int IMM_W = 16
) (
   input  logic [2:0]      op_i,
   input  logic [IMM_W-1:0] imm_i,
   input  logic [XLEN-1:0] reg_i,
   output logic [XLEN-1:0] res_o,
   output logic            hit_o
);
   import imm16_pkg::*;
   localparam int UPPER = XLEN - IMM_W;

   logic [XLEN-1:0] zext, oext, sext;

   assign zext = {{UPPER{1'b0}}, imm_i};
   assign oext = {{UPPER{1'b1}}, imm_i};
   assign sext = {{UPPER{imm_i[IMM_W-1]}}, imm_i};

   always_comb begin
      hit_o = 1'b1;
      unique case (op_i)
         OP_LDZ: res_o = zext;
         OP_LDO: res_o = oext;
         OP_ADD: res_o = reg_i + sext;
         OP_SHI: res_o = (reg_i << IMM_W) | zext;
         default: begin
            res_o = '0;
            hit_o = 1'b0;
         end
      endcase
   end
endmodule

// File: rtl/imm16_h2d.sv
module imm16_h2d (
   input  logic [15:0] half_i,
   output logic [63:0] dbl_o
);
   localparam int HM = 10;
   localparam int DM = 52;
   localparam int PAD = DM - HM;
   localparam logic [10:0] BIAS_GAP = 11'd1008;  // 1023 - 15
   localparam logic [10:0] SUB_BASE = 11'd999;   // 1023 - 24

   logic          sgn;
   logic [4:0]    ex;
   logic [HM-1:0] man;
   logic [3:0]    lead;
   logic [2*HM-1:0] shifted;
   logic [HM-1:0] nfrac;

   assign sgn = half_i[15];
   assign ex  = half_i[14:10];
   assign man = half_i[HM-1:0];

   always_comb begin
      lead = '0;
      for (int i = 0; i < HM; i++) begin
         if (man[i]) lead = 4'(i);
      end
   end

   assign shifted = {{HM{1'b0}}, man} << (4'(HM) - lead);
   assign nfrac   = shifted[HM-1:0];

   always_comb begin
      if (ex == 5'd0) begin
         if (man == '0) dbl_o = {sgn, 63'd0};
         else           dbl_o = {sgn, SUB_BASE + 11'(lead), nfrac, {PAD{1'b0}}};
      end else if (ex == 5'h1F) begin
         if (man == '0) dbl_o = {sgn, 11'h7FF, {DM{1'b0}}};
         else           dbl_o = {sgn, 11'h7FF, 1'b1, man[HM-2:0], {PAD{1'b0}}};
      end else begin
         dbl_o = {sgn, 11'(ex) + BIAS_GAP, man, {PAD{1'b0}}};
      end
   end
endmodule

// File: rtl/imm16_exec.sv
module imm16_exec #(
   parameter int XLEN     = 64,
   parameter int IMM_W    = 16,
   parameter bit HAS_HALF = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_valid,
   input  logic [2:0]      req_op,
   input  logic [15:0]     req_imm,
   input  logic [63:0]     req_reg,
   output logic            rsp_valid,
   output logic [63:0]     rsp_data,
   output logic            rsp_illegal
);
   import imm16_pkg::*;

   if (XLEN != 64 || IMM_W != 16) begin : g_bad_width
      $error("imm16_exec: port widths require XLEN=64 and IMM_W=16");
   end

   logic [XLEN-1:0] int_res, half_res, nxt_res;
   logic            int_hit, half_hit, nxt_ill;

   imm16_intops #(.XLEN(XLEN), .IMM_W(IMM_W)) u_int (
      .op_i (req_op),
      .imm_i(req_imm),
      .reg_i(req_reg),
      .res_o(int_res),
      .hit_o(int_hit)
   );

   if (HAS_HALF) begin : g_half
      logic [63:0] conv;
      imm16_h2d u_h2d (.half_i(req_imm), .dbl_o(conv));
      assign half_res = conv;
      assign half_hit = (req_op == OP_HALF);
   end else begin : g_nohalf
      assign half_res = '0;
      assign half_hit = 1'b0;
   end

   always_comb begin
      nxt_ill = 1'b0;
      if (int_hit)       nxt_res = int_res;
      else if (half_hit) nxt_res = half_res;
      else begin
         nxt_res = '0;
         nxt_ill = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid   <= 1'b0;
         rsp_data    <= '0;
         rsp_illegal <= 1'b0;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            rsp_data    <= nxt_res;
            rsp_illegal <= nxt_ill;
         end
      end
   end

   AST_ZERO_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op == OP_LDZ) |=> rsp_data[63:16] == '0);  // R1
   AST_ONE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op == OP_LDO) |=> (&rsp_data[63:16]));  // R2
   AST_INSERT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op == OP_SHI) |=> rsp_data[15:0] == $past(req_imm));  // R4
   AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_illegal) |-> rsp_data == '0);  // R8
   AST_LEGAL_NOFLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op <= 3'd3) |=> !rsp_illegal);  // R8
   AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);  // R9
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!rsp_valid && $stable(rsp_data) && $stable(rsp_illegal)));  // R10
endmodule

// File: tb/imm16_exec_tb.sv
`timescale 1ns/1ps
module imm16_exec_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [2:0]  req_op = '0;
   logic [15:0] req_imm = '0;
   logic [63:0] req_reg = '0;
   logic        rsp_valid;
   logic [63:0] rsp_data;
   logic        rsp_illegal;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   imm16_exec u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_imm(req_imm), .req_reg(req_reg), .rsp_valid(rsp_valid),
      .rsp_data(rsp_data), .rsp_illegal(rsp_illegal)
   );

   function automatic logic [63:0] ref_half(input logic [15:0] h);
      logic s;
      int e, m;
      real v;
      s = h[15];
      e = int'(h[14:10]);
      m = int'(h[9:0]);
      if (e == 31) begin
         if (m == 0) return {s, 11'h7FF, 52'd0};
         return {s, 11'h7FF, 1'b1, h[8:0], 42'd0};
      end
      if (e == 0 && m == 0) return {s, 63'd0};
      if (e == 0) v = real'(m) * (2.0 ** (-24));
      else        v = real'(1024 + m) * (2.0 ** (e - 25));
      if (s) v = -v;
      return $realtobits(v);
   endfunction

   function automatic logic [63:0] ref_res(input logic [2:0] op, input logic [15:0] imm,
                                           input logic [63:0] rv);
      case (op)
         3'd0: return {48'd0, imm};
         3'd1: return {{48{1'b1}}, imm};
         3'd2: return rv + {{48{imm[15]}}, imm};
         3'd3: return {rv[47:0], imm};
         3'd4: return ref_half(imm);
         default: return 64'd0;
      endcase
   endfunction

   function automatic string req_tag(input logic [2:0] op, input logic [15:0] imm);
      case (op)
         3'd0: return "R1";
         3'd1: return "R2";
         3'd2: return "R3";
         3'd3: return "R4";
         3'd4: begin
            if (imm[14:10] == 5'h1F || imm[14:0] == 15'd0) return "R7";
            if (imm[14:10] == 5'd0) return "R6";
            return "R5";
         end
         default: return "R8";
      endcase
   endfunction

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic run_op(input logic [2:0] op, input logic [15:0] imm, input logic [63:0] rv);
      logic [63:0] exp;
      exp = ref_res(op, imm, rv);
      @(negedge clk);
      req_valid = 1'b1;
      req_op = op;
      req_imm = imm;
      req_reg = rv;
      @(posedge clk);
      #1;
      check(req_tag(op, imm), rsp_data, exp);
      if (rsp_valid !== 1'b1 || rsp_illegal !== (op > 3'd4)) begin
         n_run++;
         n_fail++;
         $display("FAIL R9/R8: actual valid=%b ill=%b expected valid=1 ill=%b",
                  rsp_valid, rsp_illegal, (op > 3'd4));
      end
   endtask

   initial begin
      #(5.0 * 190000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [63:0] held;
      void'($urandom(32'd4242));
      repeat (3) @(posedge clk);
      #1;
      check("R11 data", rsp_data, 64'd0);
      check("R11 valid", {63'd0, rsp_valid}, 64'd0);
      check("R11 ill", {63'd0, rsp_illegal}, 64'd0);
      @(negedge clk);
      rst_n = 1'b1;

      run_op(3'd0, 16'hFFFF, 64'hDEAD_BEEF_0123_4567);  // R1
      run_op(3'd1, 16'h0000, 64'd0);                    // R2
      run_op(3'd2, 16'hFFFF, 64'd0);                    // R3 wraps to all ones
      run_op(3'd2, 16'h0001, 64'hFFFF_FFFF_FFFF_FFFF);  // R3 wraps to zero
      run_op(3'd2, 16'h8000, 64'h0000_0000_0000_7FFF);  // R3
      run_op(3'd3, 16'hABCD, 64'h1234_5678_9ABC_DEF0);  // R4
      check("R5 1.0",  ref_half(16'h3C00), 64'h3FF0000000000000);
      check("R5 -0.5", ref_half(16'hB800), 64'hBFE0000000000000);
      check("R6 min",  ref_half(16'h0001), 64'h3E70000000000000);
      run_op(3'd4, 16'h3C00, 64'd0);  // R5 1.0
      run_op(3'd4, 16'h3E00, 64'd0);  // R5 1.5
      run_op(3'd4, 16'h3A00, 64'd0);  // R5 0.75
      run_op(3'd4, 16'h0001, 64'd0);  // R6
      run_op(3'd4, 16'h8000, 64'd0);  // R7 -0
      run_op(3'd4, 16'hFC00, 64'd0);  // R7 -inf
      run_op(3'd4, 16'h7D55, 64'd0);  // R7 signalling NaN
      run_op(3'd5, 16'h1234, 64'h55);  // R8
      run_op(3'd7, 16'hFFFF, 64'h55);  // R8

      // R10: idle cycle with changed inputs must not disturb outputs
      run_op(3'd3, 16'h00AA, 64'h77);
      held = rsp_data;
      @(negedge clk);
      req_valid = 1'b0;
      req_op = 3'd0;
      req_imm = 16'h5555;
      @(posedge clk);
      #1;
      check("R10 data", rsp_data, held);
      check("R10 valid", {63'd0, rsp_valid}, 64'd0);
      check("R10 ill", {63'd0, rsp_illegal}, 64'd0);

      for (int i = 0; i < 65536; i++) run_op(3'd4, 16'(i), 64'(i));  // R5 R6 R7 sweep

      for (int i = 0; i < 3000; i++) begin
         run_op(3'($urandom_range(0, 7)), 16'($urandom), {$urandom, $urandom});
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule